// File: doc/BRIEF.md
# Disk Spindle Speed Monitor

The monitor checks spindle speed once per revolution. It measures the time between two revolution pulses by counting a selectable reference clock enable, starting from a preset value. Three count thresholds mark the slow-limit, nominal and fast-limit points of one revolution. As the count passes each threshold, the block records the fact in a value flag. On the next revolution pulse, the flags are moved into two status outputs. One status output says whether the motor should be driven harder. The other says whether the speed lies outside the tolerance band.

One clock after each accepted revolution pulse, a single-cycle internal restart clears the flags, sets them to their start values and reloads the counter. The reload value depends on an overspeed mode input. In normal mode it is the nominal-speed preset. In overspeed mode it is a larger preset, which shortens the interval the motor must beat and so moves the nominal decode to a speed about 10 % higher. A motor-start pulse forces the speed-up request high so that spin-up begins in a defined state. The speed error flag is raised only while the drive reports ready.

Top module: `spindle_speed_monitor`

## Requirements
- R1: On an accepted revolution pulse, `speed_up_o` takes the captured below-nominal flag. `out_of_tol_o` becomes the OR of the too-slow flag and the not-yet-fast-limit flag. Both are visible in the cycle after the pulse.
- R2: In the cycle after an accepted revolution pulse, a one-cycle restart takes place. It clears the below-nominal and too-slow flags, sets the not-yet-fast-limit flag to 1 and reloads the counter.
- R3: The reload value is `PRE_NORM` when `overspeed_i` is 0 during the restart cycle, and `PRE_FAST` when it is 1.
- R4: In every non-restart cycle with `rate_en_i` high, the counter rises by one. It holds at 2^CNT_W-1 and does not wrap.
- R5: A count of at least `TH_NOM` sets the below-nominal flag. A count of at least `TH_SLOW` sets the too-slow flag. A count of at least `TH_FAST` clears the not-yet-fast-limit flag. Each flag changes one cycle after the count that triggers it.
- R6: A `motor_start_i` pulse sets `speed_up_o` to 1 in the next cycle. In the same cycle as an accepted revolution pulse, the start pulse takes priority over the transfer.
- R7: `speed_err_o` is high exactly when `ready_i` is high and `out_of_tol_o` is 1.
- R8: A synchronous `rst_i` gives `speed_up_o`=1 and `out_of_tol_o`=0. It leaves the counter at 0, the below-nominal and too-slow flags at 0, and the not-yet-fast-limit flag at 1.
- R9: A revolution pulse that arrives during the restart cycle is ignored. It neither transfers nor starts a second restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rev_xfer_i | input | 1 | One-cycle pulse once per revolution |
| rate_en_i | input | 1 | Reference count enable, already rate-selected |
| overspeed_i | input | 1 | Selects the overspeed preset on reload |
| motor_start_i | input | 1 | Start pulse, forces the speed-up request |
| ready_i | input | 1 | Drive ready, gates the error flag |
| speed_up_o | output | 1 | 1 = motor too slow, increase drive |
| out_of_tol_o | output | 1 | Speed outside the tolerance band |
| speed_err_o | output | 1 | Speed error while ready |

## Verification
The bench sweeps the number of counted enables from zero to past saturation, under both presets. Every threshold therefore gets hit exactly, missed by one and passed. An off-by-one compare, a wrapping counter or a swapped preset each shows up as a flipped status at one specific count. A revolution pulse held high into the restart cycle, with a count tuned to land exactly on the nominal threshold, shows whether the design wrongly restarts a second time. A second restart loses one count and drops the speed-up request. A start pulse coinciding with a fast-motor transfer shows whether the design lets the transfer win.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    // Speed value flags captured during one revolution interval
    typedef struct packed {
        logic below_nom;   // count reached nominal threshold (slow side)
        logic too_slow;    // count reached slow-limit threshold
        logic not_fast;    // fast-limit threshold not yet reached
    } vflags_t;

    // Status registers presented at the outputs
    typedef struct packed {
        logic speed_up;
        logic out_tol;
    } status_t;

    localparam vflags_t VFLAGS_INIT = '{below_nom: 1'b0, too_slow: 1'b0, not_fast: 1'b1};
    localparam status_t STATUS_INIT = '{speed_up: 1'b1, out_tol: 1'b0};

endpackage

// File: rtl/ssm_sequencer.sv
module ssm_sequencer (
    input  logic clk_i,
    input  logic rst_i,
    input  logic rev_xfer_i,
    output logic take_o,
    output logic restart_o
);

    typedef struct packed {
        logic restart;
    } seq_t;

    seq_t seq_d, seq_q;
    logic take;

    always_comb begin
        take          = rev_xfer_i && !seq_q.restart;
        seq_d         = seq_q;
        seq_d.restart = take;
        if (rst_i) begin
            seq_d.restart = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        seq_q <= seq_d;
    end

    assign take_o    = take;
    assign restart_o = seq_q.restart;

    // R2: restart pulse exactly one clock after an accepted transfer
    a_r2_restart_follows: assert property (@(posedge clk_i) disable iff (rst_i)
        take_o |=> restart_o);

    // R9: restart never lasts two cycles, so a pulse inside it is dropped
    a_r9_single_restart: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_o |=> !restart_o);

endmodule

// File: rtl/ssm_counter.sv
module ssm_counter #(
    parameter int CNT_W    = 10,
    parameter int PRE_NORM = 0,
    parameter int PRE_FAST = 82
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load_i,
    input  logic             fast_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] PRE_NORM_C = CNT_W'(PRE_NORM);
    localparam logic [CNT_W-1:0] PRE_FAST_C = CNT_W'(PRE_FAST);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d.cnt = fast_i ? PRE_FAST_C : PRE_NORM_C;
        end else if (en_i && (cnt_q.cnt != CNT_MAX)) begin
            cnt_d.cnt = cnt_q.cnt + 1'b1;
        end
        if (rst_i) begin
            cnt_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q.cnt;

    // R3: reload picks the preset by mode
    a_r3_preset: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (cnt_o == ($past(fast_i) ? PRE_FAST_C : PRE_NORM_C)));

    // R4: a full counter stays full
    a_r4_saturate: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));

    // R4: single-step increment
    a_r4_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && en_i && cnt_o != CNT_MAX) |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/ssm_value_flags.sv
module ssm_value_flags
    import ssm_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int TH_FAST = 850,
    parameter int TH_NOM  = 900,
    parameter int TH_SLOW = 950
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] cnt_i,
    output vflags_t          flags_o
);

    localparam logic [CNT_W-1:0] TH_FAST_C = CNT_W'(TH_FAST);
    localparam logic [CNT_W-1:0] TH_NOM_C  = CNT_W'(TH_NOM);
    localparam logic [CNT_W-1:0] TH_SLOW_C = CNT_W'(TH_SLOW);

    vflags_t vf_d, vf_q;
    logic    hit_fast, hit_nom, hit_slow;

    always_comb begin
        hit_fast = (cnt_i >= TH_FAST_C);
        hit_nom  = (cnt_i >= TH_NOM_C);
        hit_slow = (cnt_i >= TH_SLOW_C);
        vf_d     = vf_q;
        if (clr_i || rst_i) begin
            vf_d = VFLAGS_INIT;
        end else begin
            if (hit_nom)  vf_d.below_nom = 1'b1;
            if (hit_slow) vf_d.too_slow  = 1'b1;
            if (hit_fast) vf_d.not_fast  = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        vf_q <= vf_d;
    end

    assign flags_o = vf_q;

    // R2: restart returns every flag to its start value
    a_r2_flags_init: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (!flags_o.below_nom && !flags_o.too_slow && flags_o.not_fast));

    // R5: nominal decode sets the below-nominal flag a cycle later
    a_r5_nom_decode: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clr_i && cnt_i >= TH_NOM_C) |=> flags_o.below_nom);

    // R5: fast-limit decode clears the not-fast flag a cycle later
    a_r5_fast_decode: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clr_i && cnt_i >= TH_FAST_C) |=> !flags_o.not_fast);

endmodule

// File: rtl/spindle_speed_monitor.sv
module spindle_speed_monitor
    import ssm_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int PRE_NORM = 0,
    parameter int PRE_FAST = 82,
    parameter int TH_FAST  = 850,
    parameter int TH_NOM   = 900,
    parameter int TH_SLOW  = 950
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic rev_xfer_i,
    input  logic rate_en_i,
    input  logic overspeed_i,
    input  logic motor_start_i,
    input  logic ready_i,
    output logic speed_up_o,
    output logic out_of_tol_o,
    output logic speed_err_o
);

    logic             take;
    logic             restart;
    logic [CNT_W-1:0] cnt;
    vflags_t          vflags;
    status_t          st_d, st_q;

    ssm_sequencer u_seq (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .rev_xfer_i(rev_xfer_i),
        .take_o    (take),
        .restart_o (restart)
    );

    ssm_counter #(
        .CNT_W   (CNT_W),
        .PRE_NORM(PRE_NORM),
        .PRE_FAST(PRE_FAST)
    ) u_cnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .load_i(restart),
        .fast_i(overspeed_i),
        .en_i  (rate_en_i),
        .cnt_o (cnt)
    );

    ssm_value_flags #(
        .CNT_W  (CNT_W),
        .TH_FAST(TH_FAST),
        .TH_NOM (TH_NOM),
        .TH_SLOW(TH_SLOW)
    ) u_flags (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (restart),
        .cnt_i  (cnt),
        .flags_o(vflags)
    );

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.speed_up = vflags.below_nom;
            st_d.out_tol  = vflags.too_slow | vflags.not_fast;
        end
        if (motor_start_i) begin
            st_d.speed_up = 1'b1;
        end
        if (rst_i) begin
            st_d = STATUS_INIT;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign speed_up_o   = st_q.speed_up;
    assign out_of_tol_o = st_q.out_tol;
    assign speed_err_o  = ready_i & st_q.out_tol;

    // R1: tolerance status follows the captured flags
    a_r1_tol_transfer: assert property (@(posedge clk_i) disable iff (rst_i)
        take |=> (out_of_tol_o == $past(vflags.too_slow | vflags.not_fast)));

    // R1: speed-up status follows below-nominal unless a start pulse overrides
    a_r1_up_transfer: assert property (@(posedge clk_i) disable iff (rst_i)
        (take && !motor_start_i) |=> (speed_up_o == $past(vflags.below_nom)));

    // R6: start pulse forces the speed-up request
    a_r6_start_preset: assert property (@(posedge clk_i) disable iff (rst_i)
        motor_start_i |=> speed_up_o);

    // R7: an error can only appear while ready
    a_r7_err_ready: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(speed_err_o) |-> ready_i);

endmodule

// File: tb/spindle_speed_monitor_tb.sv
module spindle_speed_monitor_tb;

    localparam int W      = 6;
    localparam int P_NORM = 0;
    localparam int P_FAST = 5;
    localparam int T_FAST = 30;
    localparam int T_NOM  = 40;
    localparam int T_SLOW = 50;
    localparam int C_MAX  = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst, rev_xfer, rate_en, overspeed, motor_start, ready;
    logic speed_up, out_tol, speed_err;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #4 clk = ~clk;

    spindle_speed_monitor #(
        .CNT_W(W), .PRE_NORM(P_NORM), .PRE_FAST(P_FAST),
        .TH_FAST(T_FAST), .TH_NOM(T_NOM), .TH_SLOW(T_SLOW)
    ) u_dut (
        .clk_i(clk), .rst_i(rst), .rev_xfer_i(rev_xfer), .rate_en_i(rate_en),
        .overspeed_i(overspeed), .motor_start_i(motor_start), .ready_i(ready),
        .speed_up_o(speed_up), .out_of_tol_o(out_tol), .speed_err_o(speed_err)
    );

    task automatic check(string req, logic act, logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the transfer edge
    task automatic pulse_xfer();
        rev_xfer = 1'b1;
        @(negedge clk);
        rev_xfer = 1'b0;
    endtask

    // called at the negedge of a restart cycle
    task automatic run_interval(int n);
        @(negedge clk);
        repeat (n) begin
            rate_en = 1'b1;
            @(negedge clk);
        end
        rate_en = 1'b0;
        repeat (2) @(negedge clk);
        pulse_xfer();
    endtask

    task automatic check_err(string req, logic exp_tol);
        ready = 1'b1; #1;
        check(req, speed_err, exp_tol);
        ready = 1'b0; #1;
        check(req, speed_err, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rev_xfer = 1'b0; rate_en = 1'b0; overspeed = 1'b0;
        motor_start = 1'b0; ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: status reset values
        check("R8 speed_up", speed_up, 1'b1);
        check("R8 out_tol", out_tol, 1'b0);
        check_err("R8 err", 1'b0);
        // R8: flags reset, counter at 0 -> fast-limit not reached
        pulse_xfer();
        check("R8 flags speed_up", speed_up, 1'b0);
        check("R8 flags out_tol", out_tol, 1'b1);

        // R1 R3 R4 R5 R7: sweep counts for both presets
        for (int m = 0; m < 2; m++) begin
            overspeed = (m == 1);
            @(negedge clk);
            pulse_xfer();
            for (int n = 0; n <= C_MAX + 3; n++) begin
                int c;
                logic e_up, e_tol;
                c = ((m == 1) ? P_FAST : P_NORM) + n;
                if (c > C_MAX) c = C_MAX;
                e_up  = (c >= T_NOM);
                e_tol = (c >= T_SLOW) || (c < T_FAST);
                run_interval(n);
                check("R1/R5 speed_up", speed_up, e_up);
                check("R1/R5 out_tol", out_tol, e_tol);
                check_err("R7 speed_err", e_tol);
            end
        end

        // R9: pulse held into the restart cycle is ignored
        overspeed = 1'b0;
        @(negedge clk);
        rev_xfer = 1'b1;
        @(negedge clk);
        rate_en = 1'b1;
        @(negedge clk);
        rev_xfer = 1'b0;
        repeat (T_NOM) @(negedge clk);
        rate_en = 1'b0;
        repeat (2) @(negedge clk);
        pulse_xfer();
        check("R9 no second restart (R2)", speed_up, 1'b1);
        check("R9 out_tol", out_tol, 1'b0);

        // R6: start pulse after a fast-motor transfer
        run_interval(35);
        check("R6 setup speed_up", speed_up, 1'b0);
        motor_start = 1'b1;
        @(negedge clk);
        motor_start = 1'b0;
        check("R6 start preset", speed_up, 1'b1);

        // R6: start wins over a coincident transfer
        @(negedge clk);
        repeat (35) begin rate_en = 1'b1; @(negedge clk); end
        rate_en = 1'b0;
        repeat (2) @(negedge clk);
        motor_start = 1'b1;
        pulse_xfer();
        motor_start = 1'b0;
        check("R6 start priority", speed_up, 1'b1);
        check("R6 out_tol with start", out_tol, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule